// File: doc/BRIEF.md
# Two-Client Shared Memory Port Arbiter

This block lets an instruction-side client and a data-side client share one wide memory port. The port returns read data strictly in request order and carries no tag. Each cycle the arbiter chooses at most one client request and passes it to the memory request queue. When the chosen request is a read, the arbiter also records which client issued it in a small owner FIFO. Each returning response goes to the client named at the head of that FIFO. Writes produce no response, so they record nothing.

A single enable input holds the whole block until memory is initialised and the processor has started. While enable is low, no request is forwarded and no response is delivered. Any response that arrives in that time is accepted and thrown away, and the owner FIFO is emptied. This lets a soft restart begin from a clean state even if stray data reaches the response queue.

Top module: `dual_mem_arbiter`

## Requirements
- R1: After reset the owner FIFO is empty. The first time both clients are eligible in the same cycle, client 0 (the data side) is granted.
- R2: A granted request appears on the memory request outputs in the same cycle, with the client's write flag, address and data. The client's request ready is high only in a cycle where the memory accepts that request. Client 1 is the instruction side and client 0 is the data side.
- R3: When both clients are eligible, the grant alternates. The client that was not granted at the last accepted request wins. A request that is not accepted leaves the preference unchanged.
- R4: An accepted write adds no owner entry. With only writes forwarded since the FIFO was last empty, a response that arrives while enabled is not accepted (memory response ready stays 0).
- R5: Responses are delivered in the order the reads were accepted, each to the client that issued the read. At most one client response valid is high in any cycle, and it carries the memory response data unchanged.
- R6: A read is eligible only when the owner FIFO holds fewer than ORD_DEPTH entries (default 4). A write stays eligible when the FIFO is full.
- R7: If the client that owns the head response has its response ready low, memory response ready is 0. The response stays in the memory queue and the owner entry is kept.
- R8: While enable is low, memory request valid, both client request readies and both client response valids are 0.
- R9: While enable is low, memory response ready is 1, so stray responses are discarded. The owner FIFO is emptied, and after enable rises a response is not accepted until a new read has been forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | System ready (memory initialised and processor started) |
| cli0ReqValid | input | 1 | Data-side request valid |
| cli0ReqWrite | input | 1 | Data-side request is a write |
| cli0ReqAddr | input | ADDR_W | Data-side request address |
| cli0ReqData | input | DATA_W | Data-side write data |
| cli0ReqReady | output | 1 | Data-side request accepted |
| cli1ReqValid | input | 1 | Instruction-side request valid |
| cli1ReqWrite | input | 1 | Instruction-side request is a write |
| cli1ReqAddr | input | ADDR_W | Instruction-side request address |
| cli1ReqData | input | DATA_W | Instruction-side write data |
| cli1ReqReady | output | 1 | Instruction-side request accepted |
| memReqValid | output | 1 | Request to memory valid |
| memReqReady | input | 1 | Memory request queue has space |
| memReqWrite | output | 1 | Memory request is a write |
| memReqAddr | output | ADDR_W | Memory request address |
| memReqData | output | DATA_W | Memory write data |
| memRespValid | input | 1 | Memory response available |
| memRespReady | output | 1 | Memory response consumed |
| memRespData | input | DATA_W | Memory response data |
| cli0RespValid | output | 1 | Response valid to data side |
| cli0RespReady | input | 1 | Data side can take a response |
| cli0RespData | output | DATA_W | Response data to data side |
| cli1RespValid | output | 1 | Response valid to instruction side |
| cli1RespReady | input | 1 | Instruction side can take a response |
| cli1RespData | output | DATA_W | Response data to instruction side |

## Verification
The stimulus covers several patterns, and each one separates a different fault:
- Lone reads from each client show whether the request mux selects the right client.
- Simultaneous reads over several cycles, including one cycle where memory stalls, show whether the grant alternates and whether a stalled cycle wrongly moves the preference.
- Filling the owner FIFO with reads and then offering a write shows whether the depth bound applies to reads only.
- Responses returned with the head owner not ready separate true backpressure from dropped data.
- A run of writes followed by a response, and a disable with reads outstanding, show whether writes or a drain leave stale owner entries that would misroute later data.

// File: rtl/arb_pkg.sv
package arb_pkg;
  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic grantIdx;  // 0: client 0 drives the request mux, 1: client 1
    logic pushOrd;   // record grantIdx as owner of a new read
    logic popOrd;    // head response delivered
    logic clearOrd;  // empty the owner FIFO
  } ctrlStrobesT;
endpackage

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 64,
  parameter int ORD_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  logic              cli0ReqWrite,
  input  logic [ADDR_W-1:0] cli0ReqAddr,
  input  logic [DATA_W-1:0] cli0ReqData,
  input  logic              cli1ReqWrite,
  input  logic [ADDR_W-1:0] cli1ReqAddr,
  input  logic [DATA_W-1:0] cli1ReqData,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqData,
  input  logic [DATA_W-1:0] memRespData,
  output logic [DATA_W-1:0] cli0RespData,
  output logic [DATA_W-1:0] cli1RespData,
  output logic              ordFull,
  output logic              ordEmpty,
  output logic              headOwner
);
  localparam int PTR_W = (ORD_DEPTH > 1) ? $clog2(ORD_DEPTH) : 1;
  localparam int CNT_W = $clog2(ORD_DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(ORD_DEPTH - 1);

  logic [ORD_DEPTH-1:0] ownerMem;
  logic [PTR_W-1:0]     wrPtr, rdPtr;
  logic [CNT_W-1:0]     count;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.pushOrd) ownerMem[wrPtr] <= strobes.grantIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearOrd) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobes.pushOrd) wrPtr <= nextPtr(wrPtr);
      if (strobes.popOrd)  rdPtr <= nextPtr(rdPtr);
      case ({strobes.pushOrd, strobes.popOrd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign ordFull   = (count == CNT_W'(ORD_DEPTH));
  assign ordEmpty  = (count == '0);
  assign headOwner = ownerMem[rdPtr];

  // Request mux picks the granted client
  assign memReqWrite = strobes.grantIdx ? cli1ReqWrite : cli0ReqWrite;
  assign memReqAddr  = strobes.grantIdx ? cli1ReqAddr  : cli0ReqAddr;
  assign memReqData  = strobes.grantIdx ? cli1ReqData  : cli0ReqData;

  // Response data fans out; valids select the receiver
  assign cli0RespData = memRespData;
  assign cli1RespData = memRespData;
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        cli0ReqValid,
  input  logic        cli0ReqWrite,
  input  logic        cli1ReqValid,
  input  logic        cli1ReqWrite,
  input  logic        memReqReady,
  input  logic        memRespValid,
  input  logic        cli0RespReady,
  input  logic        cli1RespReady,
  input  logic        ordFull,
  input  logic        ordEmpty,
  input  logic        headOwner,
  output ctrlStrobesT strobes,
  output logic        memReqValid,
  output logic        cli0ReqReady,
  output logic        cli1ReqReady,
  output logic        memRespReady,
  output logic        cli0RespValid,
  output logic        cli1RespValid
);
  logic rrPref;   // client favoured on the next contested cycle
  logic elig0, elig1, grantIdx, fire, grantWrite, ownerReady, respGo;

  // A read needs a free owner slot; a write does not
  assign elig0    = cli0ReqValid && (cli0ReqWrite || !ordFull);
  assign elig1    = cli1ReqValid && (cli1ReqWrite || !ordFull);
  assign grantIdx = (elig0 && elig1) ? rrPref : elig1;

  assign memReqValid  = enable && (elig0 || elig1);
  assign fire         = memReqValid && memReqReady;
  assign grantWrite   = grantIdx ? cli1ReqWrite : cli0ReqWrite;
  assign cli0ReqReady = fire && !grantIdx;
  assign cli1ReqReady = fire && grantIdx;

  always_ff @(posedge clk) begin
    if (!rstN)     rrPref <= 1'b0;
    else if (fire) rrPref <= !grantIdx;
  end

  // Response steering by the owner FIFO head
  assign ownerReady    = headOwner ? cli1RespReady : cli0RespReady;
  assign respGo        = enable && !ordEmpty && memRespValid && ownerReady;
  assign memRespReady  = enable ? (!ordEmpty && ownerReady) : 1'b1;
  assign cli0RespValid = enable && !ordEmpty && memRespValid && !headOwner;
  assign cli1RespValid = enable && !ordEmpty && memRespValid && headOwner;

  always_comb begin
    strobes.grantIdx = grantIdx;
    strobes.pushOrd  = fire && !grantWrite;
    strobes.popOrd   = respGo;
    strobes.clearOrd = !enable;
  end
endmodule

// File: rtl/dual_mem_arbiter.sv
module dual_mem_arbiter
  import arb_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 64,
  parameter int ORD_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              cli0ReqValid,
  input  logic              cli0ReqWrite,
  input  logic [ADDR_W-1:0] cli0ReqAddr,
  input  logic [DATA_W-1:0] cli0ReqData,
  output logic              cli0ReqReady,
  input  logic              cli1ReqValid,
  input  logic              cli1ReqWrite,
  input  logic [ADDR_W-1:0] cli1ReqAddr,
  input  logic [DATA_W-1:0] cli1ReqData,
  output logic              cli1ReqReady,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqData,
  input  logic              memRespValid,
  output logic              memRespReady,
  input  logic [DATA_W-1:0] memRespData,
  output logic              cli0RespValid,
  input  logic              cli0RespReady,
  output logic [DATA_W-1:0] cli0RespData,
  output logic              cli1RespValid,
  input  logic              cli1RespReady,
  output logic [DATA_W-1:0] cli1RespData
);
  ctrlStrobesT strobes;
  logic ordFull, ordEmpty, headOwner;

  arb_ctrl u_ctrl (
    .clk, .rstN, .enable,
    .cli0ReqValid, .cli0ReqWrite, .cli1ReqValid, .cli1ReqWrite,
    .memReqReady, .memRespValid, .cli0RespReady, .cli1RespReady,
    .ordFull, .ordEmpty, .headOwner,
    .strobes, .memReqValid, .cli0ReqReady, .cli1ReqReady,
    .memRespReady, .cli0RespValid, .cli1RespValid
  );

  arb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ORD_DEPTH(ORD_DEPTH)) u_dp (
    .clk, .rstN, .strobes,
    .cli0ReqWrite, .cli0ReqAddr, .cli0ReqData,
    .cli1ReqWrite, .cli1ReqAddr, .cli1ReqData,
    .memReqWrite, .memReqAddr, .memReqData,
    .memRespData, .cli0RespData, .cli1RespData,
    .ordFull, .ordEmpty, .headOwner
  );
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int ADDR_W    = 24,
  parameter int ORD_DEPTH = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              cli0ReqReady,
  input logic [ADDR_W-1:0] cli0ReqAddr,
  input logic              cli1ReqReady,
  input logic [ADDR_W-1:0] cli1ReqAddr,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWrite,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRespValid,
  input logic              memRespReady,
  input logic              cli0RespValid,
  input logic              cli0RespReady,
  input logic              cli1RespValid
);
  localparam int OUT_W = $clog2(ORD_DEPTH + 1) + 1;
  logic [OUT_W-1:0] outstanding;

  // Reads in flight, counted from the port handshakes only
  always_ff @(posedge clk) begin
    if (!rstN || !enable) outstanding <= '0;
    else outstanding <= outstanding
                        + OUT_W'(memReqValid && memReqReady && !memReqWrite)
                        - OUT_W'(memRespValid && memRespReady);
  end

  a_r6_read_bound: assert property (@(posedge clk) disable iff (!rstN)
    outstanding <= OUT_W'(ORD_DEPTH));

  a_r8_freeze: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!memReqValid && !cli0ReqReady && !cli1ReqReady && !cli0RespValid && !cli1RespValid));

  a_r9_drain: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> memRespReady);

  a_r5_one_receiver: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cli0RespValid, cli1RespValid}));

  a_r2_fwd_cli0: assert property (@(posedge clk) disable iff (!rstN)
    cli0ReqReady |-> (memReqValid && memReqReady && memReqAddr == cli0ReqAddr));

  a_r2_fwd_cli1: assert property (@(posedge clk) disable iff (!rstN)
    cli1ReqReady |-> (memReqValid && memReqReady && memReqAddr == cli1ReqAddr));

  a_r3_single_grant: assert property (@(posedge clk) disable iff (!rstN)
    !(cli0ReqReady && cli1ReqReady));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cli0RespValid && !cli0RespReady) |-> !memRespReady);
endmodule

bind dual_mem_arbiter arb_checker #(.ADDR_W(ADDR_W), .ORD_DEPTH(ORD_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable),
  .cli0ReqReady(cli0ReqReady), .cli0ReqAddr(cli0ReqAddr),
  .cli1ReqReady(cli1ReqReady), .cli1ReqAddr(cli1ReqAddr),
  .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
  .memRespValid(memRespValid), .memRespReady(memRespReady),
  .cli0RespValid(cli0RespValid), .cli0RespReady(cli0RespReady),
  .cli1RespValid(cli1RespValid)
);

// File: tb/dual_mem_arbiter_bench.sv
module dual_mem_arbiter_bench;
  localparam int AW = 24, DW = 64, DEPTH = 4;

  logic clk = 0, rstN = 0, enable = 0;
  logic c0Valid = 0, c0Write = 0, c1Valid = 0, c1Write = 0;
  logic [AW-1:0] c0Addr = '0, c1Addr = '0;
  logic [DW-1:0] c0Data = '0, c1Data = '0, mRespData = '0;
  logic mReqReady = 1, mRespValid = 0, c0RespReady = 1, c1RespReady = 1;
  logic c0ReqReady, c1ReqReady, mReqValid, mReqWrite, mRespReady;
  logic c0RespValid, c1RespValid;
  logic [AW-1:0] mReqAddr;
  logic [DW-1:0] mReqData, c0RespData, c1RespData;

  int checks = 0, errors = 0;
  bit ordQ[$];
  bit pref = 0;

  always #2 clk = ~clk;

  dual_mem_arbiter #(.ADDR_W(AW), .DATA_W(DW), .ORD_DEPTH(DEPTH)) u_dual_mem_arbiter (
    .clk, .rstN, .enable,
    .cli0ReqValid(c0Valid), .cli0ReqWrite(c0Write), .cli0ReqAddr(c0Addr),
    .cli0ReqData(c0Data), .cli0ReqReady(c0ReqReady),
    .cli1ReqValid(c1Valid), .cli1ReqWrite(c1Write), .cli1ReqAddr(c1Addr),
    .cli1ReqData(c1Data), .cli1ReqReady(c1ReqReady),
    .memReqValid(mReqValid), .memReqReady(mReqReady), .memReqWrite(mReqWrite),
    .memReqAddr(mReqAddr), .memReqData(mReqData),
    .memRespValid(mRespValid), .memRespReady(mRespReady), .memRespData(mRespData),
    .cli0RespValid(c0RespValid), .cli0RespReady(c0RespReady), .cli0RespData(c0RespData),
    .cli1RespValid(c1RespValid), .cli1RespReady(c1RespReady), .cli1RespData(c1RespData)
  );

  task automatic chk(string req, string nm, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, nm, act, exp);
    end
  endtask

  // One clock: compare against the reference model, then advance it
  task automatic cycle(string req);
    bit full, empty, e0, e1, g, mv, fire, head, ownRdy, respGo, gWrite;
    #1;
    full   = (ordQ.size() == DEPTH);
    empty  = (ordQ.size() == 0);
    head   = empty ? 1'b0 : ordQ[0];
    e0     = c0Valid && (c0Write || !full);
    e1     = c1Valid && (c1Write || !full);
    g      = (e0 && e1) ? pref : e1;
    mv     = enable && (e0 || e1);
    fire   = mv && mReqReady;
    gWrite = g ? c1Write : c0Write;
    ownRdy = head ? c1RespReady : c0RespReady;
    respGo = enable && !empty && mRespValid && ownRdy;
    chk(req, "memReqValid", 64'(mReqValid), 64'(mv));
    chk(req, "cli0ReqReady", 64'(c0ReqReady), 64'(fire && !g));
    chk(req, "cli1ReqReady", 64'(c1ReqReady), 64'(fire && g));
    if (mv) begin
      chk(req, "memReqAddr", 64'(mReqAddr), 64'(g ? c1Addr : c0Addr));
      chk(req, "memReqWrite", 64'(mReqWrite), 64'(gWrite));
      chk(req, "memReqData", mReqData, g ? c1Data : c0Data);
    end
    chk(req, "memRespReady", 64'(mRespReady), 64'(!enable || (!empty && ownRdy)));
    chk(req, "cli0RespValid", 64'(c0RespValid), 64'(enable && !empty && mRespValid && !head));
    chk(req, "cli1RespValid", 64'(c1RespValid), 64'(enable && !empty && mRespValid && head));
    if (c0RespValid) chk(req, "cli0RespData", c0RespData, mRespData);
    if (c1RespValid) chk(req, "cli1RespData", c1RespData, mRespData);
    @(posedge clk);
    if (!enable) ordQ.delete();
    else begin
      if (respGo) void'(ordQ.pop_front());
      if (fire && !gWrite) ordQ.push_back(g);
      if (fire) pref = !g;
    end
    @(negedge clk);
  endtask

  task automatic finish();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R8: disabled, requests ignored
    c0Valid = 1; c0Addr = 24'h111;
    repeat (2) cycle("R8");
    // R1: reset state, both contend, response with empty FIFO refused
    enable = 1; c1Valid = 1; c1Addr = 24'h222; mRespValid = 1; mRespData = 64'hdead;
    cycle("R1");
    c1Valid = 0; mRespValid = 0;
    // R2: lone requests from each side
    c0Addr = 24'h010; c0Data = 64'h5;
    cycle("R2");
    c0Valid = 0; c1Valid = 1; c1Addr = 24'h020; c1Data = 64'h6;
    cycle("R2");
    c1Valid = 0;
    // R5: return three responses in order
    for (int i = 0; i < 3; i++) begin
      mRespValid = 1; mRespData = 64'hA0 + 64'(i);
      cycle("R5");
    end
    mRespValid = 0;
    // R3: contention with a stalled cycle
    c0Valid = 1; c1Valid = 1; c0Addr = 24'h030; c1Addr = 24'h040;
    mReqReady = 0; cycle("R3");
    mReqReady = 1; cycle("R3");
    cycle("R3");
    c1Valid = 0;
    // R6: fill the owner FIFO, read stalls, write passes
    repeat (3) cycle("R6");
    c1Valid = 1; c1Write = 1; c1Addr = 24'h050; c1Data = 64'h77;
    repeat (2) cycle("R6");
    c0Valid = 0; c1Valid = 0; c1Write = 0;
    // R7: head owner not ready
    mRespValid = 1; mRespData = 64'hB0; c0RespReady = 0; c1RespReady = 0;
    repeat (2) cycle("R7");
    c0RespReady = 1; c1RespReady = 1;
    for (int i = 0; i < 4; i++) begin
      mRespData = 64'hC0 + 64'(i);
      cycle("R5");
    end
    mRespValid = 0;
    // R4: only writes, then a response is refused
    c0Valid = 1; c0Write = 1; c0Addr = 24'h060;
    repeat (2) cycle("R4");
    c0Valid = 0; c0Write = 0; mRespValid = 1;
    cycle("R4");
    mRespValid = 0;
    // R9: disable with reads outstanding, drain, re-enable
    c1Valid = 1; c1Addr = 24'h070;
    repeat (2) cycle("R9");
    c1Valid = 0; enable = 0; mRespValid = 1;
    repeat (2) cycle("R9");
    enable = 1;
    repeat (2) cycle("R9");
    mRespValid = 0;
    cycle("R9");
    finish();
  end
endmodule